// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Reads

This block is a 16-bit up-counter placed behind an 8-bit register port. A control register picks what drives the counter. The choices are: nothing, every bus clock, a single-cycle enable pulse from a fixed-rate clock domain already brought into the bus domain, or rising edges of an external pin that the block synchronizes itself. A power-of-two prescaler sits between the chosen source and the counter. When the count wraps from its maximum value, a sticky flag is set.

Software reads the 16-bit count one byte at a time. The first byte read, whichever it is, captures the whole count into a holding register. Later reads are served from that register until the other byte has been read. The pair therefore always belongs to one instant, in either byte order. Writing the control register drops any held capture. Writing either count byte zeroes the counter and also drops the capture.

Top module: `tc_timer`

## Requirements
- R1: After reset the control register reads 0x00, the count is zero and no capture is held.
- R2: Register addresses are 0 = control, 1 = count high byte, 2 = count low byte, and 3 reads 0x00. Control bits are: [2:0] prescale code, [4:3] source code, [7] wrap flag (read-only, so a written bit 7 is ignored). Bits [6:5] read as 0.
- R3: Source code 00 stops the counter. Code 01 advances on every bus clock. Code 10 advances on each cycle the fixed-rate enable input is high. Code 11 advances on external rising edges.
- R4: The external input passes through two flops and then an edge detector. Each rising edge gives exactly one source tick, however long the input stays high.
- R5: Prescale code p passes one counter step per 2^p source ticks (1 to 128). The prescaler is held at zero while the source code is 00. A new code governs the cycle after the write.
- R6: A read of either count byte with no capture held snapshots all 16 bits and returns its byte of the snapshot. Further reads return snapshot bytes until the opposite byte is read. That read returns its snapshot byte and releases the capture. Re-reading the first byte keeps the capture held.
- R7: Any write to the control register releases a held capture, so the next count read shows the live value.
- R8: A write of any data to either count byte sets the count to zero and releases a held capture.
- R9: A step from 0xFFFF gives 0x0000 and sets the wrap flag. The flag stays set until the control register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| fix_tick | input | 1 | Fixed-rate clock enable, bus-clock domain |
| ext_clk | input | 1 | Asynchronous external count input |

## Verification
A stuck capture flag shows up at the very next count read after the opposite byte has been read or a register write has occurred: a stale snapshot byte appears where the live value was expected. A mis-set prescaler or a missed edge does not show at once. It shows as a count that is off by a predictable amount after a known number of source ticks, and that count is read back a few cycles later. Because the external path is synchronized, a count step appears on the third bus edge after the pin rises, and a wrong register depth would move that step.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_BUS = 2'b01,
        SRC_FIX = 2'b10,
        SRC_EXT = 2'b11
    } src_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd2;
endpackage

// File: rtl/tc_ext_sync.sv
module tc_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic ext_rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sy_q, sy_d;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = ext_in;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign ext_rise = sy_q.s2 & ~sy_q.prev;

    AST_EXT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |-> $past(ext_in, 2)) else $error("external tick without input two edges back"); // R4
    AST_EXT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise) else $error("external edge gave two ticks"); // R4
endmodule

// File: rtl/tc_prescale.sv
module tc_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_tick,
    input  logic            clear,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pre_q, pre_d;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = ~({DIV_W{1'b1}} << ps);
        tick  = src_tick && ((pre_q & mask) == mask);
        pre_d = pre_q;
        if (clear)         pre_d = '0;
        else if (src_tick) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pre_q == '0)) else $error("prescaler not held while source off"); // R5
    AST_PRE_NOSRC: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> src_tick) else $error("prescaled tick without source tick"); // R5
endmodule

// File: rtl/tc_timer.sv
module tc_timer
    import tc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fix_tick,
    input  logic              ext_clk
);
    localparam int CNT_W   = 2 * DATA_W;
    localparam int SRC_LSB = PS_W;
    localparam int OVF_BIT = DATA_W - 1;

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        src_e             src;
        logic             ovf;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             held;
        logic             held_hi;
    } st_t;

    st_t  s_q, s_d;
    logic ext_rise, src_tick, cnt_tick;
    logic rd_hi, rd_lo, rd_ctrl, wr_ctrl, wr_cnt;

    tc_ext_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_clk),
        .ext_rise (ext_rise)
    );

    always_comb begin
        unique case (s_q.src)
            SRC_BUS: src_tick = 1'b1;
            SRC_FIX: src_tick = fix_tick;
            SRC_EXT: src_tick = ext_rise;
            default: src_tick = 1'b0;
        endcase
    end

    tc_prescale #(.PS_W(PS_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .clear    (s_q.src == SRC_OFF),
        .ps       (s_q.ps),
        .tick     (cnt_tick)
    );

    assign rd_ctrl = reg_rd && (reg_addr == ADDR_CTRL);
    assign rd_hi   = reg_rd && (reg_addr == ADDR_HI);
    assign rd_lo   = reg_rd && (reg_addr == ADDR_LO);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_cnt  = reg_wr && ((reg_addr == ADDR_HI) || (reg_addr == ADDR_LO));

    always_comb begin
        s_d = s_q;
        // read capture: first byte arms, opposite byte releases
        if (rd_hi || rd_lo) begin
            if (!s_q.held) begin
                s_d.held    = 1'b1;
                s_d.held_hi = rd_hi;
                s_d.snap    = s_q.cnt;
            end else if ((s_q.held_hi && rd_lo) || (!s_q.held_hi && rd_hi)) begin
                s_d.held = 1'b0;
            end
        end
        if (cnt_tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (&s_q.cnt) s_d.ovf = 1'b1;
        end
        if (wr_ctrl) begin
            s_d.ps   = reg_wdata[PS_W-1:0];
            s_d.src  = src_e'(reg_wdata[SRC_LSB +: 2]);
            s_d.ovf  = 1'b0;
            s_d.held = 1'b0;
        end
        if (wr_cnt) begin
            s_d.cnt  = '0;
            s_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_ctrl) begin
            reg_rdata[PS_W-1:0]       = s_q.ps;
            reg_rdata[SRC_LSB +: 2]   = s_q.src;
            reg_rdata[OVF_BIT]        = s_q.ovf;
        end else if (rd_hi) begin
            reg_rdata = s_q.held ? s_q.snap[CNT_W-1:DATA_W] : s_q.cnt[CNT_W-1:DATA_W];
        end else if (rd_lo) begin
            reg_rdata = s_q.held ? s_q.snap[DATA_W-1:0] : s_q.cnt[DATA_W-1:0];
        end
    end

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.src == SRC_OFF && !wr_cnt) |=> $stable(s_q.cnt)) else $error("count moved with source off"); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !(&s_q.cnt)) |=> (s_q.cnt == $past(s_q.cnt) || s_q.cnt == $past(s_q.cnt) + 1'b1)) else $error("count jumped"); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.held && ((s_q.held_hi && rd_lo) || (!s_q.held_hi && rd_hi)) && !rd_ctrl) |=> !s_q.held) else $error("capture not released"); // R6
    AST_CTRL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !s_q.held) else $error("control write left capture held"); // R7
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (s_q.cnt == '0 && !s_q.held)) else $error("count write did not clear"); // R8
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && (&s_q.cnt) && !wr_cnt && !wr_ctrl) |=> (s_q.ovf && s_q.cnt == '0)) else $error("wrap not flagged"); // R9
endmodule

// File: tb/tc_timer_tb.sv
module tc_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fix_tick = 1'b0;
    logic       ext_clk = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    tc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fix_tick(fix_tick), .ext_clk(ext_clk)
    );

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic pulse_fix(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fix_tick = 1'b1;
            @(negedge clk); fix_tick = 1'b0;
        end
    endtask

    // monitor: pops the expected item for each read strobe
    always @(negedge clk) begin
        #1;
        if (reg_rd) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_err++;
                $display("FAIL scoreboard empty: actual=%02h expected=none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rd(2'd0, 8'h00, "R1 ctrl after reset");
        rd(2'd1, 8'h00, "R1 high after reset");
        rd(2'd2, 8'h00, "R1 low after reset");
        rd(2'd3, 8'h00, "R2 unused address");
        // fixed-rate source
        wr(2'd0, 8'h10);
        rd(2'd0, 8'h10, "R2 ctrl readback");
        pulse_fix(5);
        rd(2'd1, 8'h00, "R3 fixed source high");
        rd(2'd2, 8'h05, "R3 fixed source low");
        // high-first coherent read
        wr(2'd2, 8'h5A);
        pulse_fix(255);
        rd(2'd1, 8'h00, "R6 high first");
        pulse_fix(1);
        rd(2'd2, 8'hFF, "R6 low from snapshot");
        rd(2'd1, 8'h01, "R6 high live after release");
        rd(2'd2, 8'h00, "R6 low pair");
        // low-first coherent read
        rd(2'd2, 8'h00, "R6 low first");
        pulse_fix(3);
        rd(2'd2, 8'h00, "R6 low reread held");
        rd(2'd1, 8'h01, "R6 high from snapshot");
        rd(2'd1, 8'h01, "R6 high live");
        rd(2'd2, 8'h03, "R6 low live pair");
        // control write releases
        rd(2'd1, 8'h01, "R7 arm");
        pulse_fix(2);
        wr(2'd0, 8'h10);
        rd(2'd2, 8'h05, "R7 low live after ctrl write");
        rd(2'd1, 8'h01, "R7 high pair");
        // count write clears and releases
        rd(2'd1, 8'h01, "R8 arm");
        wr(2'd1, 8'hAB);
        pulse_fix(1);
        rd(2'd2, 8'h01, "R8 low live after count write");
        rd(2'd1, 8'h00, "R8 high cleared");
        // source off
        wr(2'd0, 8'h00);
        pulse_fix(4);
        repeat (2) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        rd(2'd2, 8'h01, "R3 source off holds");
        rd(2'd1, 8'h00, "R3 source off high");
        // prescale div4 and div128
        wr(2'd0, 8'h12);
        wr(2'd2, 8'h00);
        pulse_fix(9);
        rd(2'd2, 8'h02, "R5 divide by 4");
        rd(2'd1, 8'h00, "R5 divide by 4 high");
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h17);
        wr(2'd2, 8'h00);
        pulse_fix(300);
        rd(2'd2, 8'h02, "R5 divide by 128");
        rd(2'd1, 8'h00, "R5 divide by 128 high");
        // bus source: 10 edges between the two control writes
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h08);
        repeat (8) @(negedge clk);
        wr(2'd0, 8'h00);
        rd(2'd2, 8'h0A, "R3 bus source");
        rd(2'd1, 8'h00, "R3 bus source high");
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h09);
        repeat (8) @(negedge clk);
        wr(2'd0, 8'h00);
        rd(2'd2, 8'h05, "R5 bus divide by 2");
        rd(2'd1, 8'h00, "R5 bus divide by 2 high");
        // external edges
        wr(2'd0, 8'h18);
        wr(2'd2, 8'h00);
        repeat (4) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (2) @(negedge clk);
            ext_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        @(negedge clk); ext_clk = 1'b1;
        repeat (6) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd2, 8'h05, "R4 one tick per external edge");
        rd(2'd1, 8'h00, "R4 external high");
        // wrap and flag
        wr(2'd0, 8'h10);
        wr(2'd2, 8'h00);
        @(negedge clk); fix_tick = 1'b1;
        repeat (65540) @(negedge clk);
        fix_tick = 1'b0;
        rd(2'd0, 8'h90, "R9 wrap flag set");
        rd(2'd1, 8'h00, "R9 wrapped high");
        rd(2'd2, 8'h04, "R9 wrapped low");
        wr(2'd0, 8'h90);
        rd(2'd0, 8'h10, "R9 flag cleared, R2 bit 7 read-only");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule